// File: doc/BRIEF.md
# Programmable Dual-Modulus Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It counts cycles of the fast oscillator clock and emits one feedback pulse for the phase comparator at the end of every divide period. The period length M is programmable and comes from one of two ratio rules.

In the dual rule, M is built from a 12-bit count N and a 4-bit adjust A as 2N + A + 1. A code of zero means an adjust of -1, so the ratio is then exactly 2N, and any other code counts as its binary value. A 6-bit fractional offset can be switched on in this rule. It adds offset/64 cycles to the average period: a 6-bit accumulator stretches a period by one cycle each time it overflows. In the direct rule, M is simply N. A ratio field of zero parks the divider with its output held low.

Settings are applied only at a period boundary, so software may change them at any time without producing a short or broken period. A configuration-error flag reports an illegal adjust setting for the settings currently applied.

Top module: `fbd_top`

## Requirements
- R1: With `full_mode`=1 and `a_code` nonzero, the number of `clk` cycles between consecutive `fb_pulse` highs is 2·`n_val` + `a_code` + 1 (for example, n=10, a=4 gives 25, and n=4095, a=15 gives 8206).
- R2: With `full_mode`=1 and `a_code`=0, the adjust counts as -1, so the period is exactly 2·`n_val` (for example, n=10 gives 20).
- R3: With `full_mode`=1 and `frac_en`=1, a 6-bit accumulator adds `frac_off` once per period. Each overflow past 63 lengthens that period by one cycle, so over any 64 consecutive periods the total is 64·M + `frac_off`, and each single period is M or M+1. With `frac_en`=0, no period is stretched.
- R4: With `full_mode`=0, the period is exactly `n_val`. `a_code`, `frac_off` and `frac_en` have no effect on the period or on `cfg_err`.
- R5: Every `n_val` from 1 to 4095 is a valid ratio. `n_val`=1 in the direct rule gives a pulse on every cycle.
- R6: `cfg_err` is 1 exactly when the applied settings use the dual rule with a nonzero `a_code` and either `n_val` ≤ `a_code` + 5, or `n_val` is 4, 8 or 16. Otherwise it is 0. It changes only when new settings are applied.
- R7: While the applied `n_val` is 0, `fb_pulse` stays low. In this parked state the inputs are sampled on every cycle, and a nonzero `n_val` starts a fresh period on the next edge.
- R8: New `n_val`, `a_code`, `frac_off`, `frac_en` and `full_mode` values take effect only at the clock edge that ends a period (the edge after a cycle in which `fb_pulse` is high), or at any edge while parked. The period in progress keeps its old length.
- R9: `fb_pulse` is high for exactly one cycle per period. The pulse is the last cycle of the period.
- R10: While `rst_n` is low, `fb_pulse` and `cfg_err` are 0, and the counter and the fractional accumulator are cleared. The first edge after release applies the inputs, so the first pulse shows in the M-th cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| n_val | input | 12 | Main ratio field N (0 parks the divider) |
| a_code | input | 4 | Adjust field for the dual rule (0 means -1) |
| frac_off | input | 6 | Fractional offset in 1/64 cycle steps |
| frac_en | input | 1 | Enables the fractional offset in the dual rule |
| full_mode | input | 1 | 1 selects the dual rule 2N+A+1, 0 selects the direct rule N |
| fb_pulse | output | 1 | One-cycle feedback pulse ending each period |
| cfg_err | output | 1 | Applied settings violate the adjust legality rule |

## Verification
On every cycle, the assertions check four things. Settings change only at a period boundary or while parked. A pulse is never followed by another when the newly loaded period is longer than one cycle. Applying a zero ratio silences the output. The error flag and the fractional stretch stay off whenever the dual rule or its adjust is not in use. Whether each period has the length the formulas give, whether the fractional stretch averages to exactly the offset over 64 periods, and where the first pulse falls after reset, only the bench can show. It does this by running a cycle-level reference and by counting the cycles between pulses.

// File: rtl/fbd_pkg.sv
package fbd_pkg;

  // Ratio rule selected by the mode input.
  typedef enum logic {
    RATIO_DIRECT = 1'b0,  // M = N
    RATIO_DUAL   = 1'b1   // M = 2N + A + 1 (A code 0 means -1)
  } ratio_mode_e;

endpackage

// File: rtl/fbd_ratio_calc.sv
module fbd_ratio_calc
  import fbd_pkg::*;
#(
  parameter int NW = 12,
  parameter int AW = 4,
  parameter int LW = NW + 2
) (
  input  logic [NW-1:0] n_i,
  input  logic [AW-1:0] a_i,
  input  ratio_mode_e   mode_i,
  output logic [LW-1:0] len_o,
  output logic          bad_o
);

  // Minimum margin between the adjust and the main count.
  localparam int GUARD = 5;

  // Dual rule: twice N, plus the adjust value, plus one.
  // Adjust code zero stands for -1, which cancels the +1.
  function automatic logic [LW-1:0] dual_ratio(input logic [NW-1:0] n,
                                               input logic [AW-1:0] a);
    logic [LW-1:0] twice;
    twice = LW'(n) << 1;
    if (a == '0) return twice;
    return twice + LW'(a) + LW'(1);
  endfunction

  // Main counts that cannot be combined with an adjust.
  function automatic logic forbidden_n(input logic [NW-1:0] n);
    return (n == NW'(4)) || (n == NW'(8)) || (n == NW'(16));
  endfunction

  // Legality applies only when the adjust is actually used.
  function automatic logic dual_illegal(input logic [NW-1:0] n,
                                        input logic [AW-1:0] a);
    if (a == '0) return 1'b0;
    return (LW'(n) <= (LW'(a) + LW'(GUARD))) || forbidden_n(n);
  endfunction

  always_comb begin
    if (mode_i == RATIO_DUAL) begin
      len_o = dual_ratio(n_i, a_i);
      bad_o = dual_illegal(n_i, a_i);
    end else begin
      len_o = LW'(n_i);
      bad_o = 1'b0;
    end
  end

endmodule

// File: rtl/fbd_frac_acc.sv
module fbd_frac_acc #(
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          en_i,
  input  logic [FW-1:0] off_i,
  output logic          carry_o
);

  logic [FW-1:0] acc_q;
  logic [FW:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, off_i};
    carry_o = step_i && en_i && sum[FW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (step_i && en_i) begin
      acc_q <= sum[FW-1:0];
    end
  end

endmodule

// File: rtl/fbd_counter.sv
module fbd_counter #(
  parameter int LW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [LW-1:0] load_val_i,
  output logic          zero_o
);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - LW'(1);
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/fbd_top.sv
module fbd_top
  import fbd_pkg::*;
#(
  parameter int NW = 12,
  parameter int AW = 4,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] n_val,
  input  logic [AW-1:0] a_code,
  input  logic [FW-1:0] frac_off,
  input  logic          frac_en,
  input  logic          full_mode,
  output logic          fb_pulse,
  output logic          cfg_err
);

  // Wide enough for 2N + 15 + 1 plus one stretch cycle.
  localparam int LW = NW + 2;

  ratio_mode_e   live_mode;
  logic [NW-1:0] sh_n;
  logic          err_q;
  logic          stalled;
  logic          cnt_zero;
  logic          period_end;
  logic          take;
  logic          load;
  logic [LW-1:0] new_len;
  logic          live_bad;
  logic          frac_active;
  logic          carry;
  logic [LW-1:0] load_val;

  assign live_mode   = ratio_mode_e'(full_mode);
  assign frac_active = frac_en && (live_mode == RATIO_DUAL);

  // Named events used by the checker.
  assign stalled    = (sh_n == '0);
  assign period_end = !stalled && cnt_zero;
  assign take       = stalled || period_end;
  assign load       = take && (n_val != '0);

  fbd_ratio_calc #(
    .NW(NW), .AW(AW), .LW(LW)
  ) u_ratio (
    .n_i   (n_val),
    .a_i   (a_code),
    .mode_i(live_mode),
    .len_o (new_len),
    .bad_o (live_bad)
  );

  fbd_frac_acc #(
    .FW(FW)
  ) u_frac (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (load),
    .en_i   (frac_active),
    .off_i  (frac_off),
    .carry_o(carry)
  );

  assign load_val = new_len - LW'(1) + LW'(carry);

  fbd_counter #(
    .LW(LW)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .load_val_i(load_val),
    .zero_o    (cnt_zero)
  );

  // Applied settings: the ratio field (for parking) and the legality verdict.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_n  <= '0;
      err_q <= 1'b0;
    end else if (take) begin
      sh_n  <= n_val;
      err_q <= live_bad;
    end
  end

  assign fb_pulse = period_end;
  assign cfg_err  = err_q;

endmodule

// File: rtl/fbd_checker.sv
module fbd_checker #(
  parameter int NW = 12,
  parameter int AW = 4,
  parameter int LW = NW + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NW-1:0] n_val,
  input logic [AW-1:0] a_code,
  input logic          frac_en,
  input logic          full_mode,
  input logic          fb_pulse,
  input logic          cfg_err,
  input logic          take,
  input logic          load,
  input logic [LW-1:0] new_len,
  input logic          carry,
  input logic [NW-1:0] sh_n
);

  // R7: applying a zero ratio silences the output on the next cycle.
  p_zero_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (n_val == '0)) |=> !fb_pulse);

  // R8: outside a boundary, the applied settings do not move.
  p_hold_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(sh_n) && $stable(cfg_err)));

  // R9: a newly loaded period longer than one cycle begins with a low output.
  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (new_len > LW'(1))) |=> !fb_pulse);

  // R6: the flag stays off when the dual rule or its adjust is not in use.
  p_err_scope_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (!full_mode || (a_code == '0))) |=> !cfg_err);

  // R3: a stretch cycle only when the fraction is enabled in the dual rule.
  p_carry_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> (frac_en && full_mode && load));

endmodule

bind fbd_top fbd_checker #(
  .NW(NW), .AW(AW), .LW(LW)
) u_fbd_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .n_val    (n_val),
  .a_code   (a_code),
  .frac_en  (frac_en),
  .full_mode(full_mode),
  .fb_pulse (fb_pulse),
  .cfg_err  (cfg_err),
  .take     (take),
  .load     (load),
  .new_len  (new_len),
  .carry    (carry),
  .sh_n     (sh_n)
);

// File: tb/test_fbd_top.sv
module test_fbd_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] n_val = '0;
  logic [3:0]  a_code = '0;
  logic [5:0]  frac_off = '0;
  logic        frac_en = 1'b0;
  logic        full_mode = 1'b0;
  logic        fb_pulse;
  logic        cfg_err;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #4 clk = ~clk;  // 125 MHz

  fbd_top i_fbd_top (
    .clk(clk), .rst_n(rst_n), .n_val(n_val), .a_code(a_code),
    .frac_off(frac_off), .frac_en(frac_en), .full_mode(full_mode),
    .fb_pulse(fb_pulse), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Requirement arithmetic, restated in plain integers.
  function automatic int ref_ratio(int n, int a, bit dual);
    int adj;
    if (!dual) return n;
    adj = (a == 0) ? -1 : a;
    return 2 * n + adj + 1;
  endfunction

  function automatic bit ref_bad(int n, int a, bit dual);
    if (!dual || a == 0) return 1'b0;
    return !(a < n - 5) || n == 4 || n == 8 || n == 16;
  endfunction

  // Behavioural reference: cycles left in the period, applied settings.
  int m_n = 0, m_left = 0, m_acc = 0;
  bit m_err = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_n = 0; m_left = 0; m_acc = 0; m_err = 1'b0;
    end else if (m_n == 0 || m_left == 0) begin
      m_n   = n_val;
      m_err = ref_bad(n_val, a_code, full_mode);
      if (n_val != 0) begin
        int extra;
        extra = 0;
        if (frac_en && full_mode) begin
          m_acc = m_acc + frac_off;
          if (m_acc >= 64) begin m_acc = m_acc - 64; extra = 1; end
        end
        m_left = ref_ratio(n_val, a_code, full_mode) - 1 + extra;
      end
    end else begin
      m_left = m_left - 1;
    end
  end

  // Per-cycle comparison against the reference (R9 pulse stream, R6 flag, R10 in reset).
  always @(negedge clk) begin
    bit exp_p;
    exp_p = (m_n != 0) && (m_left == 0);
    chk(fb_pulse == exp_p, rst_n ? "R9 pulse vs reference" : "R10 pulse in reset",
        int'(fb_pulse), int'(exp_p));
    chk(cfg_err == m_err, rst_n ? "R6 flag vs reference" : "R10 flag in reset",
        int'(cfg_err), int'(m_err));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got %0d expected %0d cycles", cyc, 190000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic set_cfg(int n, int a, int off, bit fe, bit dual);
    @(negedge clk);
    n_val = 12'(n); a_code = 4'(a); frac_off = 6'(off); frac_en = fe; full_mode = dual;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!fb_pulse);
  endtask

  task automatic interval(output int c);
    c = 0;
    do begin @(negedge clk); c++; end while (!fb_pulse);
  endtask

  // Skip the period in progress, then measure nper periods of the new settings.
  task automatic measure(int nper, output int total, output int lo, output int hi);
    int c;
    wait_pulse();
    total = 0; lo = 1 << 30; hi = 0;
    for (int i = 0; i < nper; i++) begin
      interval(c);
      total += c;
      if (c < lo) lo = c;
      if (c > hi) hi = c;
    end
  endtask

  initial begin
    int tot, lo, hi, c, cnt;
    n_val = 12'd9;
    repeat (4) @(negedge clk);
    chk(fb_pulse == 1'b0 && cfg_err == 1'b0, "R10 outputs low in reset", int'(fb_pulse), 0);

    // R10: first pulse in the N-th cycle after release
    rst_n = 1'b1;
    interval(c);
    chk(c == 9, "R10 first pulse after release", c, 9);

    // R4: direct rule ignores adjust and fraction
    set_cfg(5, 7, 33, 1'b1, 1'b0);
    measure(8, tot, lo, hi);
    chk(tot == 40 && lo == 5 && hi == 5, "R4 direct rule period", tot, 40);
    chk(cfg_err == 1'b0, "R4 flag unaffected by adjust", int'(cfg_err), 0);

    // R5: ratio one pulses every cycle
    set_cfg(1, 0, 0, 1'b0, 1'b0);
    measure(4, tot, lo, hi);
    chk(tot == 4, "R5 ratio one", tot, 4);

    // R2: adjust code zero means -1
    set_cfg(10, 0, 0, 1'b0, 1'b1);
    measure(3, tot, lo, hi);
    chk(lo == 20 && hi == 20, "R2 code zero gives 2N", hi, 20);

    // R1: nonzero adjust counts its value
    set_cfg(10, 3, 0, 1'b0, 1'b1);
    measure(3, tot, lo, hi);
    chk(lo == 24 && hi == 24, "R1 n=10 a=3", hi, 24);
    set_cfg(10, 4, 0, 1'b0, 1'b1);
    measure(3, tot, lo, hi);
    chk(lo == 25 && hi == 25, "R1 n=10 a=4", hi, 25);
    chk(cfg_err == 1'b0, "R6 a=4 n=10 legal", int'(cfg_err), 0);

    // R3: fraction 21/64 over 64 periods
    set_cfg(20, 1, 21, 1'b1, 1'b1);
    measure(64, tot, lo, hi);
    chk(tot == 64 * 42 + 21, "R3 fractional total", tot, 64 * 42 + 21);
    chk(lo == 42 && hi == 43, "R3 single period bounds", hi - lo, 1);
    set_cfg(20, 1, 21, 1'b0, 1'b1);
    measure(16, tot, lo, hi);
    chk(lo == 42 && hi == 42, "R3 no stretch when disabled", hi, 42);

    // R6: legality cases
    set_cfg(8, 3, 0, 1'b0, 1'b1);
    measure(1, tot, lo, hi);
    chk(cfg_err == 1'b1, "R6 a=3 n=8", int'(cfg_err), 1);
    set_cfg(16, 1, 0, 1'b0, 1'b1);
    measure(1, tot, lo, hi);
    chk(cfg_err == 1'b1, "R6 n=16 forbidden", int'(cfg_err), 1);
    set_cfg(20, 15, 0, 1'b0, 1'b1);
    measure(1, tot, lo, hi);
    chk(cfg_err == 1'b1, "R6 a=15 n=20 boundary", int'(cfg_err), 1);
    set_cfg(21, 15, 0, 1'b0, 1'b1);
    measure(1, tot, lo, hi);
    chk(cfg_err == 1'b0, "R6 a=15 n=21 legal", int'(cfg_err), 0);
    set_cfg(6, 0, 0, 1'b0, 1'b1);
    measure(1, tot, lo, hi);
    chk(cfg_err == 1'b0, "R6 adjust unused", int'(cfg_err), 0);

    // R7: zero ratio parks the output, then restarts
    set_cfg(0, 3, 0, 1'b0, 1'b1);
    wait_pulse();
    cnt = 0;
    repeat (300) begin @(negedge clk); if (fb_pulse) cnt++; end
    chk(cnt == 0, "R7 no pulses while parked", cnt, 0);
    set_cfg(3, 0, 0, 1'b0, 1'b0);
    interval(c);
    chk(c == 3, "R7 restart from parked", c, 3);

    // R8: change mid-period, old length kept
    set_cfg(100, 0, 0, 1'b0, 1'b1);
    wait_pulse();
    c = 0;
    do begin
      @(negedge clk); c++;
      if (c == 50) begin n_val = 12'd7; full_mode = 1'b0; end
    end while (!fb_pulse);
    chk(c == 200, "R8 period in progress kept", c, 200);
    interval(c);
    chk(c == 7, "R8 new setting after boundary", c, 7);

    // R5 / R1: extremes of the range
    set_cfg(4095, 0, 0, 1'b0, 1'b0);
    measure(2, tot, lo, hi);
    chk(lo == 4095 && hi == 4095, "R5 n=4095 direct", hi, 4095);
    set_cfg(4095, 15, 0, 1'b0, 1'b1);
    measure(2, tot, lo, hi);
    chk(lo == 8206 && hi == 8206, "R1 n=4095 a=15", hi, 8206);

    // R10: reset mid-run
    set_cfg(9, 0, 0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(fb_pulse == 1'b0 && cfg_err == 1'b0, "R10 reset mid-run", int'(fb_pulse), 0);
    rst_n = 1'b1;
    interval(c);
    chk(c == 9, "R10 first pulse after second release", c, 9);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule